// File: doc/BRIEF.md
# Event-Driven Timer Output Set/Clear Unit

This block holds the level of seven timer output lines and changes them in response to eight single-cycle event strobes. Each output owns two 8-bit masks. The set mask lists the events that drive the line high. The clear mask lists the events that drive it low. A 2-bit direction selector per output can exchange the two masks while a chosen counter half counts down. This makes it possible to build centre-aligned waveforms from a single pair of events.

The surrounding timer supplies the event strobes, the down-count flags of its low and high counter halves, their halt flags, and a flag that says whether the counter runs as two 16-bit halves or as one unified counter. When the counter is split, no output may move while either half is halted. When it is unified, only the low (unified) halt flag gates updates. Software programs the masks and selectors through a simple word-addressed write port with combinational readback.

Both the output levels and the configuration are registered. An event in cycle t is seen on the output pins in cycle t+1. Reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `evout_unit`

## Requirements
- R1: When event m fires and bit m of output n's set mask is 1 (no swap active, not held), out_o[n] is 1 in the following cycle.
- R2: When event m fires and bit m of output n's clear mask is 1 (no swap active, not held), out_o[n] is 0 in the following cycle.
- R3: After reset, all outputs are 0 and all masks and selectors read back 0, so no event changes any output until the unit is configured.
- R4: With selector value 1, while cnt_down_lo_i is 1, the set mask clears output n and the clear mask sets it.
- R5: With selector value 2 in split mode, while cnt_down_hi_i is 1, the set mask clears output n and the clear mask sets it.
- R6: With selector value 0 or 3, the masks keep their normal meaning whatever the direction flags are.
- R7: In split mode (split_i=1), if halt_lo_i or halt_hi_i is 1, no output changes in the following cycle.
- R8: In unified mode (split_i=0), only halt_lo_i blocks updates, and halt_hi_i has no effect.
- R9: If output n sees an effective set and an effective clear in the same cycle, it toggles.
- R10: Register map: set mask n is at word address 2n and clear mask n at 2n+1, each in bits 7:0. The selectors are at address 14, with output n's selector in bits 2n+1:2n. Address 15 holds nothing. Unused write bits are ignored and read back as 0.
- R11: In unified mode, selector values 1 and 2 both follow cnt_down_lo_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 8 | Event strobes, bit m is event m |
| cnt_down_lo_i | input | 1 | Low (or unified) counter half is counting down |
| cnt_down_hi_i | input | 1 | High counter half is counting down |
| halt_lo_i | input | 1 | Low (or unified) counter half is halted |
| halt_hi_i | input | 1 | High counter half is halted |
| split_i | input | 1 | Counter runs as two 16-bit halves |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Combinational readback of the addressed word |
| out_o | output | 7 | Registered output levels |

## Verification
Two pairs of functions can land in the same cycle: a set and a clear on one output, and a direction swap on top of the halt gating. The stimulus table fires event 7, which every output clears on, together with events 0 and 1, whose set masks also target outputs 0 and 1. The expected result is a toggle from each output's known previous level. Other vectors apply halt and down-count flags in the same cycle as swapped events. They judge that split-mode halts win outright, and that in unified mode the high-half halt and direction flags are ignored.

// File: rtl/evout_pkg.sv
package evout_pkg;
  localparam int NUM_OUT = 7;
  localparam int NUM_EV  = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;

  typedef enum logic [1:0] {
    DS_NONE = 2'd0,
    DS_LO   = 2'd1,
    DS_HI   = 2'd2,
    DS_RSV  = 2'd3
  } dirsel_e;
endpackage

// File: rtl/evout_cfg.sv
module evout_cfg
  import evout_pkg::*;
#(
  parameter int NO = NUM_OUT,
  parameter int NE = NUM_EV,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic [NO-1:0][NE-1:0]  set_q,
  output logic [NO-1:0][NE-1:0]  clr_q,
  output logic [NO-1:0][1:0]     dsel_q
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(2*NO);

  logic [NO-1:0][NE-1:0] set_d, clr_d;
  logic [NO-1:0][1:0]    dsel_d;

  // next-state
  always_comb begin
    set_d  = set_q;
    clr_d  = clr_q;
    dsel_d = dsel_q;
    for (int i = 0; i < NO; i++) begin
      if (addr == AW'(2*i))   set_d[i] = wdata[NE-1:0];
      if (addr == AW'(2*i+1)) clr_d[i] = wdata[NE-1:0];
    end
    if (addr == CTRL_ADDR) dsel_d = wdata[2*NO-1:0];
  end

  // registers, write strobe used as clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= '0;
      clr_q  <= '0;
      dsel_q <= '0;
    end else if (we) begin
      set_q  <= set_d;
      clr_q  <= clr_d;
      dsel_q <= dsel_d;
    end
  end

  // readback
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NO; i++) begin
      if (addr == AW'(2*i))   rdata[NE-1:0] = set_q[i];
      if (addr == AW'(2*i+1)) rdata[NE-1:0] = clr_q[i];
    end
    if (addr == CTRL_ADDR) rdata[2*NO-1:0] = dsel_q;
  end
endmodule

// File: rtl/evout_gate.sv
module evout_gate (
  input  logic split,
  input  logic halt_lo,
  input  logic halt_hi,
  input  logic down_hi,
  input  logic down_lo,
  output logic hold,
  output logic down_hi_eff
);
  // Split mode: either half halted freezes outputs; unified: low flag only.
  assign hold        = split ? (halt_lo | halt_hi) : halt_lo;
  // Unified mode has a single direction, carried by the low flag.
  assign down_hi_eff = split ? down_hi : down_lo;
endmodule

// File: rtl/evout_lane.sv
module evout_lane
  import evout_pkg::*;
#(
  parameter int NE = NUM_EV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] ev,
  input  logic [NE-1:0] set_mask,
  input  logic [NE-1:0] clr_mask,
  input  logic [1:0]    dsel,
  input  logic          down_lo,
  input  logic          down_hi,
  input  logic          hold,
  output logic          set_hit,
  output logic          clr_hit,
  output logic          out_q
);
  dirsel_e mode;
  logic    swap, raw_s, raw_c, upd_en, out_d;

  assign mode  = dirsel_e'(dsel);
  assign swap  = ((mode == DS_LO) && down_lo) || ((mode == DS_HI) && down_hi);
  assign raw_s = |(ev & set_mask);
  assign raw_c = |(ev & clr_mask);

  assign set_hit = swap ? raw_c : raw_s;
  assign clr_hit = swap ? raw_s : raw_c;
  assign upd_en  = !hold && (set_hit || clr_hit);

  always_comb begin
    unique case ({set_hit, clr_hit})
      2'b11:   out_d = ~out_q;
      2'b10:   out_d = 1'b1;
      2'b01:   out_d = 1'b0;
      default: out_d = out_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= 1'b0;
    else if (upd_en) out_q <= out_d;
  end
endmodule

// File: rtl/evout_unit.sv
module evout_unit
  import evout_pkg::*;
#(
  parameter int NO = NUM_OUT,
  parameter int NE = NUM_EV,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] ev_i,
  input  logic          cnt_down_lo_i,
  input  logic          cnt_down_hi_i,
  input  logic          halt_lo_i,
  input  logic          halt_hi_i,
  input  logic          split_i,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic [DW-1:0] cfg_rdata_o,
  output logic [NO-1:0] out_o
);
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic [NO-1:0][NE-1:0] set_mask, clr_mask;
  logic [NO-1:0][1:0]    dsel;
  logic                  hold, down_hi_eff;
  logic [NO-1:0]         set_hit, clr_hit;

  evout_cfg #(.NO(NO), .NE(NE), .DW(DW), .AW(AW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (cfg_we_i),
    .addr  (cfg_addr_i),
    .wdata (cfg_wdata_i),
    .rdata (cfg_rdata_o),
    .set_q (set_mask),
    .clr_q (clr_mask),
    .dsel_q(dsel)
  );

  evout_gate u_gate (
    .split      (split_i),
    .halt_lo    (halt_lo_i),
    .halt_hi    (halt_hi_i),
    .down_hi    (cnt_down_hi_i),
    .down_lo    (cnt_down_lo_i),
    .hold       (hold),
    .down_hi_eff(down_hi_eff)
  );

  for (genvar n = 0; n < NO; n++) begin : g_lane
    evout_lane #(.NE(NE)) u_lane (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .ev      (ev_i),
      .set_mask(set_mask[n]),
      .clr_mask(clr_mask[n]),
      .dsel    (dsel[n]),
      .down_lo (cnt_down_lo_i),
      .down_hi (down_hi_eff),
      .hold    (hold),
      .set_hit (set_hit[n]),
      .clr_hit (clr_hit[n]),
      .out_q   (out_o[n])
    );
  end
endmodule

// File: rtl/evout_chk.sv
module evout_chk #(
  parameter int NO = 7,
  parameter int NE = 8,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          split_i,
  input logic          halt_lo_i,
  input logic          halt_hi_i,
  input logic [NE-1:0] ev_i,
  input logic [AW-1:0] cfg_addr_i,
  input logic [DW-1:0] cfg_rdata_o,
  input logic [NO-1:0] set_hit,
  input logic [NO-1:0] clr_hit,
  input logic [NO-1:0] out_o
);
  logic held;
  assign held = split_i ? (halt_lo_i || halt_hi_i) : halt_lo_i;

  p_split_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (split_i && (halt_lo_i || halt_hi_i)) |=> $stable(out_o));

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == '0) |=> $stable(out_o));

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && |(set_hit & ~clr_hit)) |=>
      ((out_o & $past(set_hit & ~clr_hit)) == $past(set_hit & ~clr_hit)));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && |(clr_hit & ~set_hit)) |=>
      ((out_o & $past(clr_hit & ~set_hit)) == '0));

  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && |(set_hit & clr_hit)) |=>
      (((out_o ^ $past(out_o)) & $past(set_hit & clr_hit)) == $past(set_hit & clr_hit)));

  p_rdata_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr_i != AW'(2*NO)) |-> (cfg_rdata_o[DW-1:NE] == '0));
endmodule

bind evout_unit evout_chk #(.NO(NO), .NE(NE), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .split_i    (split_i),
  .halt_lo_i  (halt_lo_i),
  .halt_hi_i  (halt_hi_i),
  .ev_i       (ev_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_rdata_o(cfg_rdata_o),
  .set_hit    (set_hit),
  .clr_hit    (clr_hit),
  .out_o      (out_o)
);

// File: tb/tb_evout_unit.sv
module tb_evout_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ev_i;
  logic        cnt_down_lo_i, cnt_down_hi_i, halt_lo_i, halt_hi_i, split_i;
  logic        cfg_we_i;
  logic [3:0]  cfg_addr_i;
  logic [31:0] cfg_wdata_i, cfg_rdata_o;
  logic [6:0]  out_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  evout_unit dut (.*);

  typedef struct packed {
    logic [7:0] ev;
    logic       dlo, dhi, hlo, hhi, split;
    logic [6:0] expv;
    logic [3:0] req;
  } vec_t;

  // Config: set mask n = event n, every clear mask = event 7,
  // selectors out0=0, out1=1, out2=2, out3=3, rest 0.
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{8'h7F, 1'b0,1'b0,1'b0,1'b0,1'b0, 7'h7F, 4'd1},  // R1 set all
    '{8'h80, 1'b0,1'b0,1'b0,1'b0,1'b0, 7'h00, 4'd2},  // R2 clear all
    '{8'h01, 1'b0,1'b0,1'b0,1'b0,1'b0, 7'h01, 4'd1},  // R1
    '{8'h80, 1'b0,1'b0,1'b1,1'b0,1'b0, 7'h01, 4'd8},  // R8 unified halt blocks
    '{8'h80, 1'b0,1'b0,1'b0,1'b1,1'b0, 7'h00, 4'd8},  // R8 high halt ignored
    '{8'h06, 1'b0,1'b0,1'b0,1'b1,1'b1, 7'h00, 4'd7},  // R7 high halted
    '{8'h06, 1'b0,1'b0,1'b1,1'b0,1'b1, 7'h00, 4'd7},  // R7 low halted
    '{8'h06, 1'b0,1'b0,1'b0,1'b0,1'b1, 7'h06, 4'd7},  // R7 running
    '{8'h80, 1'b1,1'b0,1'b0,1'b0,1'b1, 7'h02, 4'd4},  // R4 clear mask sets out1
    '{8'h02, 1'b1,1'b0,1'b0,1'b0,1'b1, 7'h00, 4'd4},  // R4 set mask clears out1
    '{8'h0C, 1'b0,1'b1,1'b0,1'b0,1'b1, 7'h08, 4'd5},  // R5 out2 cleared, out3 set (R6)
    '{8'h80, 1'b1,1'b1,1'b0,1'b0,1'b1, 7'h06, 4'd6},  // R6 out0/out3 normal
    '{8'h83, 1'b0,1'b0,1'b0,1'b0,1'b0, 7'h01, 4'd9},  // R9 toggles
    '{8'h80, 1'b0,1'b1,1'b0,1'b0,1'b0, 7'h00, 4'd11}, // R11 unified ignores high dir
    '{8'h80, 1'b1,1'b0,1'b0,1'b0,1'b0, 7'h06, 4'd11}, // R11 both follow low dir
    '{8'h81, 1'b0,1'b0,1'b0,1'b0,1'b0, 7'h01, 4'd9}   // R9 toggle from 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] expv);
    @(negedge clk);
    cfg_addr_i = a;
    #1 check(req, cfg_rdata_o, expv);
  endtask

  task automatic idle();
    ev_i = '0; cnt_down_lo_i = 0; cnt_down_hi_i = 0;
    halt_lo_i = 0; halt_hi_i = 0; split_i = 0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_we_i = 0; cfg_addr_i = '0; cfg_wdata_i = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset state
    check("R3 out after reset", {25'd0, out_o}, 32'd0);
    for (int a = 0; a < 15; a++) rd_check("R3 readback zero", 4'(a), 32'd0);
    @(negedge clk); ev_i = 8'hFF;
    @(negedge clk); ev_i = 8'h00;
    check("R3 unconfigured events", {25'd0, out_o}, 32'd0);

    // R10 register map
    wr(4'd3, 32'hDEAD_BEAA);
    rd_check("R10 clear mask 1 upper bits dropped", 4'd3, 32'h0000_00AA);
    rd_check("R10 set mask 1 untouched", 4'd2, 32'd0);
    wr(4'd15, 32'hFFFF_FFFF);
    rd_check("R10 address 15 empty", 4'd15, 32'd0);

    // configure
    for (int n = 0; n < 7; n++) begin
      wr(4'(2*n), 32'(1 << n));
      wr(4'(2*n+1), 32'h80);
    end
    wr(4'd14, 32'hFFFF_00E4);
    rd_check("R10 selector field", 4'd14, 32'h0000_00E4);
    rd_check("R10 set mask 4", 4'd8, 32'h10);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ev_i = VEC[i].ev; cnt_down_lo_i = VEC[i].dlo; cnt_down_hi_i = VEC[i].dhi;
      halt_lo_i = VEC[i].hlo; halt_hi_i = VEC[i].hhi; split_i = VEC[i].split;
      @(negedge clk);
      idle();
      check($sformatf("R%0d vector %0d", VEC[i].req, i), {25'd0, out_o}, {25'd0, VEC[i].expv});
    end

    // R7 hold across several cycles: everything halted, events firing
    @(negedge clk); split_i = 1; halt_hi_i = 1; ev_i = 8'hFF;
    repeat (3) @(negedge clk);
    check("R7 multi-cycle hold", {25'd0, out_o}, 32'h01);
    idle();

    // R3 reset mid-run clears outputs and config
    @(negedge clk); rst_n = 1'b0;
    #1 check("R3 async reset out", {25'd0, out_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_check("R3 mask reset", 4'd0, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule